// File: doc/BRIEF.md
# I2C Register Configuration Master

After reset, this block writes a fixed list of register settings into one peripheral over a two-wire I2C bus and then leaves the bus idle for good. The list is a constant given at elaboration. Each 16-bit entry holds a 7-bit register address and a 9-bit value. The block sends every entry as its own write transfer. The peripheral may refuse to acknowledge any byte. When it does, the block ends that transfer and sends the same entry again from the start, until the peripheral has acknowledged all of it.

The block drives SCL as a push-pull output. It drives SDA only as an open-drain pull-down enable, and an external pull-up supplies the high level. The resolved line comes back on `sda_i`. A status vector has one bit per entry, and a finished flag shows when the whole list has been delivered. Bus timing comes from a quarter-period tick, Q system clocks long, where Q = max(2, ceil(CLK_HZ / (4·BUS_HZ))). Each bit slot lasts four quarters, so SCL never runs faster than BUS_HZ. With the default 50 MHz clock and 20 kHz bus, every phase is well beyond the standard-mode minimums.

Top module: `i2c_cfg_master`

## Requirements
- R1: While reset is asserted, SCL is high, SDA is released (`sda_low_o` = 0), `status_o` is all zeros and `finished_o` is 0.
- R2: Each transfer is START, then three bytes, then STOP. Every byte goes MSB first and is followed by an acknowledge slot in which SDA is released. The first byte is the DEV_ADDR parameter (default 8'h34). The second byte is {register address[6:0], value[8]}. The third byte is value[7:0].
- R3: Entry i is TABLE[16i+15:16i], with bits [15:9] the register address and bits [8:0] the value. Entries are delivered in ascending index order, starting from entry 0.
- R4: SDA changes only while SCL is low. The two exceptions are START, where SDA falls while SCL is high, and STOP, where SDA rises while SCL is high. The block never changes `scl_o` and `sda_low_o` on the same clock edge. START and STOP appear only at byte boundaries.
- R5: Every SCL low phase lasts exactly 2Q clock cycles. Every SCL high phase lasts at least 2Q clock cycles.
- R6: SDA high during an acknowledge slot is a NACK. A NACK on any byte ends the transfer with a STOP right after that slot. The same entry is then resent from its device address byte. The number of NACK-terminated transfers equals the number of refusals the peripheral made.
- R7: Status bit i sets only after all three bytes of entry i have been acknowledged. Status bits never clear, at most one sets per cycle, and they fill from bit 0 upward.
- R8: `finished_o` rises in the same cycle as the last status bit. From then on SCL stays high and SDA stays released.
- R9: Between a STOP and the next START, SCL is high and SDA is released for at least 4Q clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Resolved level of the SDA line |
| scl_o | output | 1 | SCL, driven push-pull |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |
| status_o | output | N_ENTRIES | Bit i set once entry i has been acknowledged in full |
| finished_o | output | 1 | All entries delivered |

## Verification
The assertions check the following on every cycle: SCL and the SDA drive never move on the same edge, the status vector only grows one bit at a time as a thermometer, the finished flag equals the AND of all status bits, and the bus stays idle once finished. Frame content, entry order, SCL phase widths, bus free time and the retry after a refused acknowledge depend on the bytes the peripheral returns. Only the bench's scenarios can show these. The bench uses a peripheral model that refuses acknowledges in several periodic patterns, and it compares the number of aborted transfers against a count worked out in advance.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP,
    ST_FREE
  } bus_st_e;

  localparam int unsigned FRAME_W = 24;

  // device byte, then {reg_addr, value[8]}, then value[7:0]
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [7:0] dev,
                                                    input logic [15:0] ent);
    logic [6:0] reg_a;
    logic [8:0] val;
    reg_a = ent[15:9];
    val   = ent[8:0];
    return {dev, reg_a, val[8], val[7:0]};
  endfunction

endpackage

// File: rtl/i2c_cfg_tick.sv
module i2c_cfg_tick #(
  parameter int unsigned QUARTER = 625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/i2c_cfg_phy.sv
module i2c_cfg_phy
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned QUARTER = 625
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               sda_i,
  output logic               done_o,
  output logic               ok_o,
  output logic               scl_o,
  output logic               sda_low_o
);
  bus_st_e            st_q, st_d;
  logic [1:0]         ph_q, ph_d;
  logic [2:0]         bit_q, bit_d;
  logic [1:0]         byte_q, byte_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               nack_q;
  logic               scl_q, scl_d;
  logic               sdal_q, sdal_d;
  logic               done_q, ok_q;
  logic [1:0]         sync_q;
  logic               tick, fin, run;

  assign run = (st_q != ST_IDLE);

  i2c_cfg_tick #(.QUARTER(QUARTER)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  // slot sequencing, four quarters per slot
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    sr_d   = sr_q;
    fin    = 1'b0;
    if (st_q == ST_IDLE) begin
      if (go_i) begin
        st_d   = ST_START;
        ph_d   = 2'd0;
        sr_d   = frame_i;
        byte_d = 2'd0;
        bit_d  = 3'd7;
      end
    end else if (tick) begin
      if (ph_q != 2'd3) begin
        ph_d = ph_q + 2'd1;
      end else begin
        ph_d = 2'd0;
        unique case (st_q)
          ST_START: begin
            st_d  = ST_BIT;
            bit_d = 3'd7;
          end
          ST_BIT: begin
            sr_d = {sr_q[FRAME_W-2:0], 1'b0};
            if (bit_q == 3'd0) st_d = ST_ACK;
            else               bit_d = bit_q - 3'd1;
          end
          ST_ACK: begin
            if (nack_q || byte_q == 2'd2) begin
              st_d = ST_STOP;
            end else begin
              st_d   = ST_BIT;
              bit_d  = 3'd7;
              byte_d = byte_q + 2'd1;
            end
          end
          ST_STOP: st_d = ST_FREE;
          ST_FREE: begin
            st_d = ST_IDLE;
            fin  = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  // line levels for the coming phase; SDA moves only in quarter 1..3 of a slot
  always_comb begin
    scl_d  = 1'b1;
    sdal_d = sdal_q;
    unique case (st_d)
      ST_START: sdal_d = ph_d[1];
      ST_BIT: begin
        scl_d = ph_d[1];
        if (ph_d != 2'd0) sdal_d = ~sr_d[FRAME_W-1];
      end
      ST_ACK: begin
        scl_d = ph_d[1];
        if (ph_d != 2'd0) sdal_d = 1'b0;
      end
      ST_STOP: begin
        scl_d = ph_d[1];
        if (ph_d == 2'd1 || ph_d == 2'd2) sdal_d = 1'b1;
        else if (ph_d == 2'd3)            sdal_d = 1'b0;
      end
      default: sdal_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 2'd0;
      bit_q  <= 3'd7;
      byte_q <= 2'd0;
      sr_q   <= '0;
      nack_q <= 1'b0;
      scl_q  <= 1'b1;
      sdal_q <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      sync_q <= 2'b11;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      sr_q   <= sr_d;
      scl_q  <= scl_d;
      sdal_q <= sdal_d;
      sync_q <= {sync_q[0], sda_i};
      done_q <= fin;
      ok_q   <= fin && !nack_q;
      if (st_q == ST_IDLE && go_i)
        nack_q <= 1'b0;
      else if (tick && st_q == ST_ACK && ph_q == 2'd2)
        nack_q <= sync_q[1];
    end
  end

  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign scl_o     = scl_q;
  assign sda_low_o = sdal_q;
endmodule

// File: rtl/i2c_cfg_seq.sv
module i2c_cfg_seq
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned      N_ENTRIES = 10,
  parameter logic [7:0]       DEV_ADDR  = 8'h34,
  parameter logic [16*N_ENTRIES-1:0] TABLE = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 xfer_done_i,
  input  logic                 xfer_ok_i,
  output logic                 go_o,
  output logic [FRAME_W-1:0]   frame_o,
  output logic [N_ENTRIES-1:0] status_o,
  output logic                 finished_o
);
  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_ENTRIES - 1);

  logic [IW-1:0]        idx_q;
  logic                 pending_q;
  logic                 fin_q;
  logic [N_ENTRIES-1:0] status_q;
  logic [15:0]          ent;

  always_comb begin
    ent = '0;
    for (int i = 0; i < int'(N_ENTRIES); i++)
      if (idx_q == IW'(i)) ent = TABLE[16*i +: 16];
  end

  assign frame_o = pack_frame(DEV_ADDR, ent);
  assign go_o    = !pending_q && !fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      pending_q <= 1'b0;
      fin_q     <= 1'b0;
      status_q  <= '0;
    end else begin
      if (go_o) pending_q <= 1'b1;
      if (xfer_done_i) begin
        pending_q <= 1'b0;
        if (xfer_ok_i) begin
          status_q[idx_q] <= 1'b1;
          if (idx_q == LAST_IDX) fin_q <= 1'b1;
          else                   idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign status_o   = status_q;
  assign finished_o = fin_q;
endmodule

// File: rtl/i2c_cfg_master.sv
module i2c_cfg_master
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned      CLK_HZ    = 50_000_000,
  parameter int unsigned      BUS_HZ    = 20_000,
  parameter int unsigned      N_ENTRIES = 10,
  parameter logic [7:0]       DEV_ADDR  = 8'h34,
  parameter logic [16*N_ENTRIES-1:0] TABLE = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sda_i,
  output logic                 scl_o,
  output logic                 sda_low_o,
  output logic [N_ENTRIES-1:0] status_o,
  output logic                 finished_o
);
  localparam int unsigned Q_RAW   = (CLK_HZ + 4*BUS_HZ - 1) / (4*BUS_HZ);
  localparam int unsigned QUARTER = (Q_RAW < 2) ? 2 : Q_RAW;

  logic               go, xfer_done, xfer_ok;
  logic [FRAME_W-1:0] frame;

  i2c_cfg_seq #(
    .N_ENTRIES (N_ENTRIES),
    .DEV_ADDR  (DEV_ADDR),
    .TABLE     (TABLE)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xfer_done_i (xfer_done),
    .xfer_ok_i   (xfer_ok),
    .go_o        (go),
    .frame_o     (frame),
    .status_o    (status_o),
    .finished_o  (finished_o)
  );

  i2c_cfg_phy #(.QUARTER(QUARTER)) u_phy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .frame_i   (frame),
    .sda_i     (sda_i),
    .done_o    (xfer_done),
    .ok_o      (xfer_ok),
    .scl_o     (scl_o),
    .sda_low_o (sda_low_o)
  );
endmodule

// File: rtl/i2c_cfg_master_chk.sv
module i2c_cfg_master_chk #(
  parameter int unsigned N = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_o,
  input logic         sda_low_o,
  input logic [N-1:0] status_o,
  input logic         finished_o
);
  logic [N-1:0] status_inc;
  assign status_inc = status_o + N'(1);

  always @(posedge clk_i) begin
    if (!rst_ni)
      a_r1_reset_idle: assert (scl_o && !sda_low_o && status_o == '0 && !finished_o)
        else $error("R1 reset state");
  end

  a_r4_no_joint_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_o) |-> $stable(sda_low_o));

  a_r7_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & $past(status_o)) == $past(status_o));

  a_r7_status_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o ^ $past(status_o)) <= 1);

  a_r3_status_thermo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_inc & status_o) == '0);

  a_r8_finished_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finished_o == (&status_o));

  a_r8_idle_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finished_o |-> (scl_o && !sda_low_o));
endmodule

bind i2c_cfg_master i2c_cfg_master_chk #(.N(N_ENTRIES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_o      (scl_o),
  .sda_low_o  (sda_low_o),
  .status_o   (status_o),
  .finished_o (finished_o)
);

// File: tb/i2c_cfg_master_test.sv
`timescale 1ns/1ps
module i2c_cfg_master_test;
  localparam int N      = 4;
  localparam int CLK_HZ = 790_000;
  localparam int BUS_HZ = 20_000;
  localparam int Q      = (CLK_HZ + 4*BUS_HZ - 1) / (4*BUS_HZ);
  localparam logic [7:0] DEV = 8'h34;

  function automatic logic [15:0] ent(input int i);
    logic [6:0] a;
    logic [8:0] v;
    a = 7'(i*3 + 1);
    v = 9'(9'h1A5 ^ 9'(i*37));
    return {a, v};
  endfunction

  function automatic logic [16*N-1:0] mk_table();
    logic [16*N-1:0] t;
    for (int i = 0; i < N; i++) t[16*i +: 16] = ent(i);
    return t;
  endfunction

  localparam logic [16*N-1:0] TBL = mk_table();

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic slave_low = 1'b0;
  logic scl_w, sda_low_w, fin_w, sda_w;
  logic [N-1:0] status_w;

  always #4 clk = ~clk;

  assign sda_w = !(sda_low_w || slave_low);

  i2c_cfg_master #(
    .CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ), .N_ENTRIES(N), .DEV_ADDR(DEV), .TABLE(TBL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda_w),
    .scl_o(scl_w), .sda_low_o(sda_low_w), .status_o(status_w), .finished_o(fin_w)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit timed_out = 0;
  bit mon_en = 0;
  int deny_m = 0, deny_c = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit denied(input int m, input int c, input int k);
    return (m != 0) && ((k % m) == c);
  endfunction

  function automatic int exp_nacks(input int m, input int c);
    int k = 0, nk = 0, p;
    for (int e = 0; e < N; e++) begin
      forever begin
        p = -1;
        for (int j = 0; j < 3; j++)
          if (p < 0 && denied(m, c, k + j)) p = j;
        if (p < 0) begin k += 3; break; end
        nk++;
        k += p + 1;
      end
    end
    return nk;
  endfunction

  // peripheral model and bus monitor
  bit prev_scl, prev_sda, prev_ml, in_xfer, ack_ph, nack, seen_stop;
  int bitcnt, nbytes, bytek, succ, nacks, low_len, high_len, since_stop;
  logic [7:0] shreg;
  logic [7:0] rx [3];
  logic [N-1:0] prev_status;
  bit cur_scl, cur_sda, cur_ml;

  always @(negedge clk) if (mon_en) begin
    cur_scl = scl_w; cur_sda = sda_w; cur_ml = sda_low_w;
    if (cur_scl != prev_scl) chk(cur_ml == prev_ml, "R4 SDA drive moved with SCL", cur_ml, prev_ml);
    since_stop++;
    if (cur_scl && prev_scl && cur_sda != prev_sda) begin
      if (!cur_sda) begin
        chk(!in_xfer && bitcnt == 0, "R4 START at byte boundary", bitcnt, 0);
        if (seen_stop) chk(since_stop >= 4*Q, "R9 bus free time", since_stop, 4*Q);
        in_xfer = 1; nbytes = 0; nack = 0; bitcnt = 0; ack_ph = 0;
      end else begin
        chk(bitcnt == 1 && !ack_ph, "R4 STOP at byte boundary", bitcnt, 1);
        if (nack) nacks++;
        else if (nbytes == 3) begin
          chk(rx[0] == DEV, "R2 device address byte", rx[0], DEV);
          if (succ < N)
            chk({rx[1], rx[2]} == ent(succ), "R3 entry content and order", {rx[1], rx[2]}, ent(succ));
          succ++;
        end else chk(0, "R6 transfer ended without NACK", nbytes, 3);
        in_xfer = 0; bitcnt = 0; seen_stop = 1; since_stop = 0;
      end
    end else if (cur_scl && !prev_scl) begin
      chk(low_len == 2*Q, "R5 SCL low width", low_len, 2*Q);
      low_len = 0;
      if (ack_ph) begin
        if (cur_sda) nack = 1;
      end else if (bitcnt < 8) begin
        shreg = {shreg[6:0], cur_sda};
        bitcnt++;
      end
    end else if (!cur_scl && prev_scl) begin
      chk(high_len >= 2*Q, "R5 SCL high width", high_len, 2*Q);
      high_len = 0;
      if (ack_ph) begin
        slave_low = 0; ack_ph = 0; bitcnt = 0;
      end else if (bitcnt == 8) begin
        if (nbytes < 3) rx[nbytes] = shreg;
        slave_low = !denied(deny_m, deny_c, bytek);
        bytek++; nbytes++; ack_ph = 1;
      end
    end
    if (cur_scl) high_len++; else low_len++;
    if (status_w != prev_status) begin
      chk(status_w == N'((1 << succ) - 1), "R7 status after confirmed entries", status_w, (1 << succ) - 1);
      chk(fin_w == (succ == N), "R8 finished with last status bit", fin_w, succ == N);
      prev_status = status_w;
    end
    prev_scl = cur_scl; prev_sda = cur_sda; prev_ml = cur_ml;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190_000) timed_out = 1;
  end

  task automatic run_round(input int m, input int c);
    int bad_idle;
    mon_en = 0; rst_n = 0; slave_low = 0; deny_m = m; deny_c = c;
    prev_scl = 1; prev_sda = 1; prev_ml = 0; in_xfer = 0; ack_ph = 0; nack = 0;
    seen_stop = 0; bitcnt = 0; nbytes = 0; bytek = 0; succ = 0; nacks = 0;
    low_len = 0; high_len = 4*Q; since_stop = 0; prev_status = '0;
    repeat (4) @(negedge clk);
    chk(scl_w && !sda_low_w && !fin_w && status_w == '0, "R1 reset state",
        {scl_w, sda_low_w, fin_w, status_w}, {1'b1, 1'b0, 1'b0, N'(0)});
    rst_n = 1; mon_en = 1;
    while (!fin_w && !timed_out) @(negedge clk);
    if (timed_out) return;
    @(negedge clk);
    chk(succ == N, "R3 all entries delivered", succ, N);
    chk(nacks == exp_nacks(m, c), "R6 retried transfers", nacks, exp_nacks(m, c));
    chk(&status_w, "R7 all status bits set", status_w, (1 << N) - 1);
    bad_idle = 0;
    for (int i = 0; i < 50*Q; i++) begin
      @(negedge clk);
      if (!scl_w || sda_low_w) bad_idle++;
    end
    chk(bad_idle == 0, "R8 bus idle after finish", bad_idle, 0);
    mon_en = 0;
  endtask

  initial begin
    #3 rst_n = 0;
    run_round(0, 0);
    if (!timed_out) run_round(4, 0);
    if (!timed_out) run_round(4, 2);
    if (!timed_out) run_round(5, 1);
    if (!timed_out) run_round(6, 4);
    if (!timed_out) run_round(7, 3);
    if (timed_out) chk(0, "R8 watchdog expired before finish", cyc, 190_000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule